// File: doc/BRIEF.md
# Digital PLL Lock Detector

This block decides whether a phase-locked loop has settled. It watches the two strobes that feed a phase-frequency detector: the reference and the divided feedback. It measures how far apart their rising edges fall by counting ticks of a fast sampling clock. After a programmed number of back-to-back comparisons have all come in under the lock window, it raises a lock flag.

The flag has hysteresis. Once it is set, it is dropped only when a comparison shows a skew beyond a second, wider loss-of-lock threshold. Comparisons that fall between the two thresholds leave the flag as it is.

A 2-bit select chooses the required run length. A range bit chooses between a wide and a narrow threshold pair. A disable bit forces the flag low. The strobes are assumed to be already synchronous to the sampling clock.

Top module: `pll_lock_detect`

## Requirements
- R1: After reset, `locked` is 0.
- R2: The skew of a comparison is the number of sampling-clock cycles between the detected rising edge of the first strobe and the detected rising edge of the other strobe, in either order. Edges detected in the same cycle give a skew of 0. The skew counter saturates at its maximum. A comparison is in-window when its skew is strictly less than the window threshold.
- R3: `cnt_sel` sets the run of consecutive in-window comparisons that sets `locked`: 00 needs 5, 01 needs 16, 10 needs 64 and 11 needs 255. `locked` stays 0 after one comparison fewer than that.
- R4: While unlocked, any comparison that is not in-window clears the run, so the full count must be repeated.
- R5: While locked, `locked` stays 1 for every comparison whose skew is at or below the loss threshold. It drops to 0 on a comparison whose skew is above it.
- R6: With `win_low`=0, the window is 8 ticks and the loss threshold is 16 ticks. With `win_low`=1, they are 3 and 6 ticks.
- R7: If one strobe shows a second rising edge before the other strobe has shown one, that comparison counts as out of window, and as beyond the loss threshold. The second edge then starts a new measurement.
- R8: While `det_off` is 1, `locked` is 0 one cycle later and the run is cleared. After `det_off` returns to 0, a full run is needed to lock again.
- R9: `locked` changes only as a result of a completed comparison, or of `det_off`. Suppose the closing rising edge is sampled at clock edge P. Then `locked` still shows its old value after P, and shows its new value after P+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_stb | input | 1 | Reference strobe into the PFD |
| fb_stb | input | 1 | Feedback strobe into the PFD |
| cnt_sel | input | 2 | Required run length select (R3) |
| win_low | input | 1 | Threshold range select, 1 = narrow (R6) |
| det_off | input | 1 | 1 turns lock detection off (R8) |
| locked | output | 1 | Lock flag |

## Verification
The hardest situation to reach from the ports is a strobe that edges twice before its partner edges once. In that case a bad comparison and the start of a fresh measurement happen in the same cycle. A dedicated task produces this pattern: two reference pulses a chosen gap apart, then one feedback pulse. Random runs mix it in at a low rate.

The other hard-to-reach states are long runs at the 64 and 255 settings, and skews sitting exactly on each threshold. Directed sequences build the run to one below its target, then add the final comparison. Skews are stepped onto each threshold value, one tick under it and one tick over it.

// File: rtl/pld_pkg.sv
`timescale 1ns/1ps
package pld_pkg;

  typedef enum logic [1:0] {
    MEAS_IDLE = 2'd0,
    MEAS_REF  = 2'd1,
    MEAS_FB   = 2'd2
  } meas_st_t;

  localparam int RUN_W = 8;

  function automatic logic [RUN_W-1:0] run_target(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8'd5;
      2'b01:   return 8'd16;
      2'b10:   return 8'd64;
      default: return 8'd255;
    endcase
  endfunction

endpackage

// File: rtl/pld_edge.sv
`timescale 1ns/1ps
module pld_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stb;
  end

  assign rise = stb & ~prev_q;

endmodule

// File: rtl/pld_skew.sv
`timescale 1ns/1ps
module pld_skew #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_ref,
  input  logic             rise_fb,
  output logic             pair_vld,
  output logic             pair_bad,
  output logic [CNT_W-1:0] pair_skew
);
  import pld_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meas_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vld_d, bad_d;
  logic [CNT_W-1:0] skew_d;
  logic             first_rise, other_rise;

  // In a waiting state, pick which strobe opened the measurement.
  always_comb begin
    first_rise = (st_q == MEAS_REF) ? rise_ref : rise_fb;
    other_rise = (st_q == MEAS_REF) ? rise_fb  : rise_ref;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    bad_d  = 1'b0;
    skew_d = pair_skew;
    case (st_q)
      MEAS_IDLE: begin
        if (rise_ref && rise_fb) begin
          vld_d  = 1'b1;
          skew_d = '0;
        end else if (rise_ref) begin
          st_d  = MEAS_REF;
          cnt_d = CNT_ONE;
        end else if (rise_fb) begin
          st_d  = MEAS_FB;
          cnt_d = CNT_ONE;
        end
      end
      MEAS_REF, MEAS_FB: begin
        if (other_rise) begin
          vld_d  = 1'b1;
          skew_d = cnt_q;
          st_d   = MEAS_IDLE;
        end else if (first_rise) begin
          // Same strobe edged twice: flag this comparison, restart.
          vld_d  = 1'b1;
          bad_d  = 1'b1;
          skew_d = CNT_MAX;
          cnt_d  = CNT_ONE;
        end else if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      default: st_d = MEAS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= MEAS_IDLE;
      cnt_q     <= '0;
      pair_vld  <= 1'b0;
      pair_bad  <= 1'b0;
      pair_skew <= '0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      pair_vld <= vld_d;
      pair_bad <= bad_d;
      if (vld_d) pair_skew <= skew_d;
    end
  end

endmodule

// File: rtl/pld_lock_fsm.sv
`timescale 1ns/1ps
module pld_lock_fsm #(
  parameter int CNT_W   = 6,
  parameter int WIN_HI  = 8,
  parameter int LOSS_HI = 16,
  parameter int WIN_LO  = 3,
  parameter int LOSS_LO = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pair_vld,
  input  logic                      pair_bad,
  input  logic [CNT_W-1:0]          pair_skew,
  input  logic [1:0]                cnt_sel,
  input  logic                      win_low,
  input  logic                      det_off,
  output logic                      locked,
  output logic [pld_pkg::RUN_W-1:0] run_cnt,
  output logic [pld_pkg::RUN_W-1:0] run_need
);
  import pld_pkg::*;

  localparam logic [CNT_W-1:0] WIN_HI_V  = CNT_W'(WIN_HI);
  localparam logic [CNT_W-1:0] LOSS_HI_V = CNT_W'(LOSS_HI);
  localparam logic [CNT_W-1:0] WIN_LO_V  = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] LOSS_LO_V = CNT_W'(LOSS_LO);

  logic             lock_q, lock_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [RUN_W:0]   run_inc;
  logic [CNT_W-1:0] win_lim, loss_lim;
  logic             in_win, beyond;

  always_comb begin
    win_lim  = win_low ? WIN_LO_V  : WIN_HI_V;
    loss_lim = win_low ? LOSS_LO_V : LOSS_HI_V;
    in_win   = !pair_bad && (pair_skew < win_lim);
    beyond   = pair_bad || (pair_skew > loss_lim);
    run_need = run_target(cnt_sel);
    run_inc  = {1'b0, run_q} + {{RUN_W{1'b0}}, 1'b1};
  end

  always_comb begin
    lock_d = lock_q;
    run_d  = run_q;
    if (det_off) begin
      lock_d = 1'b0;
      run_d  = '0;
    end else if (pair_vld) begin
      if (!lock_q) begin
        if (in_win) begin
          if (run_inc >= {1'b0, run_need}) begin
            lock_d = 1'b1;
            run_d  = '0;
          end else begin
            run_d = run_inc[RUN_W-1:0];
          end
        end else begin
          run_d = '0;
        end
      end else if (beyond) begin
        lock_d = 1'b0;
        run_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else begin
      lock_q <= lock_d;
      run_q  <= run_d;
    end
  end

  assign locked  = lock_q;
  assign run_cnt = run_q;

endmodule

// File: rtl/pll_lock_detect.sv
`timescale 1ns/1ps
module pll_lock_detect #(
  parameter int CNT_W   = 6,
  parameter int WIN_HI  = 8,
  parameter int LOSS_HI = 16,
  parameter int WIN_LO  = 3,
  parameter int LOSS_LO = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_stb,
  input  logic       fb_stb,
  input  logic [1:0] cnt_sel,
  input  logic       win_low,
  input  logic       det_off,
  output logic       locked
);
  import pld_pkg::*;

  localparam int NUM_STB = 2;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NUM_STB-1:0] stb_in, stb_rise;
  logic               pair_vld, pair_bad;
  logic [CNT_W-1:0]   pair_skew;
  logic [RUN_W-1:0]   run_cnt, run_need;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign stb_in = {fb_stb, ref_stb};

  for (genvar g = 0; g < NUM_STB; g++) begin : g_edge
    pld_edge u_edge (
      .clk  (clk),
      .rst_n(rst_int_n),
      .stb  (stb_in[g]),
      .rise (stb_rise[g])
    );
  end

  pld_skew #(.CNT_W(CNT_W)) u_skew (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rise_ref (stb_rise[0]),
    .rise_fb  (stb_rise[1]),
    .pair_vld (pair_vld),
    .pair_bad (pair_bad),
    .pair_skew(pair_skew)
  );

  pld_lock_fsm #(
    .CNT_W  (CNT_W),
    .WIN_HI (WIN_HI),
    .LOSS_HI(LOSS_HI),
    .WIN_LO (WIN_LO),
    .LOSS_LO(LOSS_LO)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pair_vld (pair_vld),
    .pair_bad (pair_bad),
    .pair_skew(pair_skew),
    .cnt_sel  (cnt_sel),
    .win_low  (win_low),
    .det_off  (det_off),
    .locked   (locked),
    .run_cnt  (run_cnt),
    .run_need (run_need)
  );

endmodule

// File: rtl/pld_checker.sv
`timescale 1ns/1ps
module pld_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       det_off,
  input logic       locked,
  input logic       pair_vld,
  input logic       pair_bad,
  input logic [7:0] run_cnt,
  input logic [7:0] run_need
);

  p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |=> !locked);

  p_rise_on_good_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(pair_vld) && !$past(pair_bad)));

  p_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(pair_vld) || $past(det_off)));

  p_run_reached_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ({1'b0, $past(run_cnt)} + 9'd1 >= {1'b0, $past(run_need)}));

  p_locked_run_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (run_cnt == 8'd0));

endmodule

bind pll_lock_detect pld_checker u_pld_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .det_off (det_off),
  .locked  (locked),
  .pair_vld(pair_vld),
  .pair_bad(pair_bad),
  .run_cnt (run_cnt),
  .run_need(run_need)
);

// File: tb/pll_lock_detect_bench.sv
`timescale 1ns/1ps
module pll_lock_detect_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_stb, fb_stb;
  logic [1:0] cnt_sel;
  logic       win_low;
  logic       det_off;
  logic       locked;

  int n_vec = 0;
  int n_bad = 0;
  bit m_locked = 1'b0;
  int m_run = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_lock_detect u_pll_lock_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_stb(ref_stb),
    .fb_stb (fb_stb),
    .cnt_sel(cnt_sel),
    .win_low(win_low),
    .det_off(det_off),
    .locked (locked)
  );

  function automatic int need_of(input logic [1:0] s);
    case (s)
      2'b00:   return 5;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 255;
    endcase
  endfunction

  function automatic int win_of(input logic lo);
    return lo ? 3 : 8;
  endfunction

  function automatic int loss_of(input logic lo);
    return lo ? 6 : 16;
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: locked=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_pair(input bit bad, input int skew);
    if (det_off) begin
      m_locked = 1'b0;
      m_run = 0;
    end else if (!m_locked) begin
      if (!bad && skew < win_of(win_low)) begin
        m_run++;
        if (m_run >= need_of(cnt_sel)) begin
          m_locked = 1'b1;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
    end else if (bad || skew > loss_of(win_low)) begin
      m_locked = 1'b0;
      m_run = 0;
    end
  endtask

  // One-cycle pulses; k cycles from the first strobe's rise to the other's.
  task automatic drive_pair(input bit ref_first, input int k, input string req);
    bit old;
    for (int j = 0; j <= k; j++) begin
      @(negedge clk);
      ref_stb = ref_first ? (j == 0) : (j == k);
      fb_stb  = ref_first ? (j == k) : (j == 0);
    end
    old = m_locked;
    @(negedge clk);
    ref_stb = 1'b0;
    fb_stb  = 1'b0;
    check("R9", locked, old);
    model_pair(1'b0, k);
    @(negedge clk);
    check(req, locked, m_locked);
    @(negedge clk);
  endtask

  // Reference pulses at 0 and d (d >= 2), feedback k cycles after the second.
  task automatic drive_double(input int d, input int k, input string req);
    bit old;
    for (int j = 0; j <= d + k; j++) begin
      @(negedge clk);
      ref_stb = (j == 0) || (j == d);
      fb_stb  = (j == d + k);
      if (j == d) begin
        old = m_locked;
        model_pair(1'b1, 0);
      end
      if (j == d + 2 && k >= 2) check(req, locked, m_locked);
    end
    old = m_locked;
    @(negedge clk);
    ref_stb = 1'b0;
    fb_stb  = 1'b0;
    check("R9", locked, old);
    model_pair(1'b0, k);
    @(negedge clk);
    check(req, locked, m_locked);
    @(negedge clk);
  endtask

  task automatic run_n(input int n, input int k, input string req);
    for (int i = 0; i < n; i++) drive_pair(i[0], k, req);
  endtask

  task automatic set_off(input bit v, input string req);
    @(negedge clk);
    det_off = v;
    if (v) begin
      m_locked = 1'b0;
      m_run = 0;
    end
    @(negedge clk);
    @(negedge clk);
    check(req, locked, m_locked);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: locked=%0b expected run to end", locked);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    int k;
    int r;
    seed = 32'h1d5c;
    r = $urandom(seed);
    rst_n = 1'b0;
    ref_stb = 1'b0;
    fb_stb = 1'b0;
    cnt_sel = 2'b00;
    win_low = 1'b0;
    det_off = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", locked, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", locked, 1'b0);

    // Run of 5, wide range, both strobe orders.
    run_n(4, 3, "R3");
    drive_pair(1'b1, 0, "R3");

    // Hysteresis band and the loss boundary.
    drive_pair(1'b1, 12, "R5");
    drive_pair(1'b0, 16, "R5");
    drive_pair(1'b1, 17, "R5");

    // Window boundary: 7 counts, 8 does not and clears the run.
    run_n(3, 7, "R2");
    drive_pair(1'b0, 8, "R4");
    run_n(4, 1, "R4");
    drive_pair(1'b1, 2, "R4");

    // Narrow range.
    win_low = 1'b1;
    drive_pair(1'b1, 6, "R6");
    drive_pair(1'b0, 7, "R6");
    run_n(4, 2, "R6");
    drive_pair(1'b1, 3, "R6");
    run_n(5, 2, "R6");

    // A double edge while locked drops the lock; the second edge measures on.
    drive_double(2, 1, "R7");
    run_n(4, 2, "R7");
    drive_double(3, 2, "R7");
    run_n(5, 1, "R7");

    // Disable and re-enable.
    win_low = 1'b0;
    set_off(1'b1, "R8");
    run_n(6, 1, "R8");
    set_off(1'b0, "R8");
    run_n(4, 1, "R8");
    drive_pair(1'b0, 1, "R8");
    drive_pair(1'b1, 20, "R5");

    // Longer run settings.
    cnt_sel = 2'b01;
    run_n(15, 4, "R3");
    drive_pair(1'b1, 4, "R3");
    drive_pair(1'b0, 30, "R5");
    cnt_sel = 2'b10;
    run_n(63, 5, "R3");
    drive_pair(1'b0, 5, "R3");
    drive_pair(1'b1, 40, "R5");
    cnt_sel = 2'b11;
    run_n(254, 0, "R3");
    drive_pair(1'b1, 0, "R3");
    drive_pair(1'b0, 17, "R5");

    // Random mix.
    cnt_sel = 2'b00;
    for (int i = 0; i < 600; i++) begin
      r = $urandom;
      if (r[7:0] < 8'd12 && m_run == 0) cnt_sel = r[9] ? 2'b01 : 2'b00;
      if (r[15:8] < 8'd10) win_low = r[16];
      k = (r[20:17] < 4'd11) ? (r[24:21] % 5) : (r[28:23] % 24);
      if (r[31:29] == 3'd0) drive_double(2 + r[2:1], 1 + (k % 8), "R7");
      else drive_pair(r[3], k, "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule